// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the ordered list of column addresses the burst touches. A single-cycle start pulse supplies a starting column, a length of four or eight beats, and an ordering mode (sequential or interleaved). The block then presents one column per beat on an output stream, marking the final beat.

Every address stays inside the aligned group of columns whose size equals the burst length, so the burst wraps at the group edge instead of crossing it. Only the low column bits move. For eight-beat sequential bursts the order works in nibbles: the bottom two bits count upward modulo four inside the starting half-group, then bit 2 flips and the same two-bit count repeats. Interleaved order XORs the beat number into the low bits.

The output is a valid/ready stream. A beat is consumed on a cycle where both `valid_o` and `ready_i` are high. While `ready_i` is low, the presented column and last flag stay unchanged and the beat does not advance. The burst parameters are sampled only when the block is idle.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `valid_o` and `last_o` are low and stay low until a start is accepted.
- R2: A `start_i` pulse while `valid_o` is low is accepted. In the next cycle `valid_o` is high and `col_o` equals the sampled `start_col_i` (beat 0).
- R3: With `bl8_i`=0 and `intlv_i`=0 (four-beat sequential), bits [1:0] of beat i equal (start[1:0] + i) mod 4.
- R4: With `bl8_i`=0 and `intlv_i`=1 (four-beat interleaved), bits [1:0] of beat i equal start[1:0] XOR i.
- R5: With `bl8_i`=1 and `intlv_i`=0 (eight-beat sequential), bits [1:0] of beat i equal (start[1:0] + i) mod 4. Bit 2 equals start[2] for beats 0..3 and its inverse for beats 4..7. For example, start 1 gives 1,2,3,0,5,6,7,4.
- R6: With `bl8_i`=1 and `intlv_i`=1 (eight-beat interleaved), bits [2:0] of beat i equal start[2:0] XOR i.
- R7: Column bits at and above bit 2 (four-beat) or bit 3 (eight-beat) equal the start column's bits on every beat, so the burst wraps inside its aligned group.
- R8: `last_o` is high exactly on beat 3 (four-beat) or beat 7 (eight-beat). After that beat is consumed, `valid_o` is low in the next cycle.
- R9: While `valid_o` is high and `ready_i` is low, `col_o`, `last_o` and `valid_o` hold their values into the next cycle.
- R10: A `start_i` pulse while `valid_o` is high is ignored; the running burst continues with its original order and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst request pulse, honoured only when idle |
| start_col_i | input | COL_W | Starting column of the burst |
| bl8_i | input | 1 | Burst length: 0 = four beats, 1 = eight beats |
| intlv_i | input | 1 | Ordering: 0 = sequential, 1 = interleaved |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | Current beat is presented |
| ready_i | input | 1 | Consumer accepts the current beat |
| last_o | output | 1 | Current beat is the final one of the burst |

## Verification
Beat 0 appears one clock edge after an accepted start. Each later beat appears one edge after the handshake that consumed its predecessor, and `valid_o` falls one edge after the final handshake. The bench drives inputs and samples outputs on the falling clock edge. It keeps its own beat index, which advances only when it held `ready_i` high across the preceding rising edge, so every sample is compared with the beat due in that cycle. Random back-pressure and start pulses injected mid-burst test that stalls and ignored requests leave the expected sequence in place.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  localparam int BEAT_W = 3;

  typedef struct packed {
    logic bl8;
    logic intlv;
  } burst_cfg_t;

  typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/bsq_beat_ctrl.sv
module bsq_beat_ctrl
  import bsq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  burst_cfg_t       cfg_i,
  input  logic             ready_i,
  output logic             active_o,
  output beat_t            beat_o,
  output logic             last_o,
  output logic [COL_W-1:0] col_q_o,
  output burst_cfg_t       cfg_q_o
);
  localparam beat_t LAST4 = beat_t'(3);
  localparam beat_t LAST8 = beat_t'(7);

  logic             active_q;
  beat_t            beat_q;
  logic [COL_W-1:0] col_q;
  burst_cfg_t       cfg_q;
  logic             at_last;

  assign at_last = active_q && (beat_q == (cfg_q.bl8 ? LAST8 : LAST4));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      col_q    <= '0;
      cfg_q    <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        beat_q   <= '0;
        col_q    <= col_i;
        cfg_q    <= cfg_i;
      end
    end else if (ready_i) begin
      beat_q <= beat_q + beat_t'(1);
      if (at_last) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign last_o   = at_last;
  assign col_q_o  = col_q;
  assign cfg_q_o  = cfg_q;
endmodule

// File: rtl/bsq_col_order.sv
module bsq_col_order
  import bsq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  burst_cfg_t       cfg_i,
  input  beat_t            beat_i,
  output logic [COL_W-1:0] col_o
);
  logic [1:0] low2;
  logic       bit2;

  always_comb begin
    if (cfg_i.intlv) low2 = base_i[1:0] ^ beat_i[1:0];
    else             low2 = base_i[1:0] + beat_i[1:0];
    bit2 = cfg_i.bl8 ? (base_i[2] ^ beat_i[2]) : base_i[2];
  end

  generate
    if (COL_W > 3) begin : g_wide
      assign col_o = {base_i[COL_W-1:3], bit2, low2};
    end else begin : g_narrow
      assign col_o = {bit2, low2};
    end
  endgenerate
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bsq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             bl8_i,
  input  logic             intlv_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  input  logic             ready_i,
  output logic             last_o
);
  burst_cfg_t       cfg_in;
  burst_cfg_t       cfg_q;
  beat_t            beat;
  logic [COL_W-1:0] base_col;
  logic             active;

  assign cfg_in.bl8   = bl8_i;
  assign cfg_in.intlv = intlv_i;

  bsq_beat_ctrl #(.COL_W(COL_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .col_i    (start_col_i),
    .cfg_i    (cfg_in),
    .ready_i  (ready_i),
    .active_o (active),
    .beat_o   (beat),
    .last_o   (last_o),
    .col_q_o  (base_col),
    .cfg_q_o  (cfg_q)
  );

  bsq_col_order #(.COL_W(COL_W)) order_i (
    .base_i (base_col),
    .cfg_i  (cfg_q),
    .beat_i (beat),
    .col_o  (col_o)
  );

  assign valid_o = active;
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             bl8_i,
  input logic             intlv_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             ready_i,
  input logic             last_o
);
  logic [2:0] cnt;
  logic       len8;
  logic       il;
  logic [2:0] slow;
  logic       hs;

  assign hs = valid_o && ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; len8 <= 1'b0; il <= 1'b0; slow <= '0;
    end else if (!valid_o && start_i) begin
      cnt <= '0; len8 <= bl8_i; il <= intlv_i; slow <= start_col_i[2:0];
    end else if (hs) begin
      cnt <= cnt + 3'd1;
    end
  end

  p_idle_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> !last_o);

  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && start_i) |=> (valid_o && col_o == $past(start_col_i)));

  p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !last_o && !il) |=> (col_o[1:0] == $past(col_o[1:0]) + 2'd1));

  p_intlv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && il && len8) |-> (col_o[2:0] == (slow ^ cnt)));

  p_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !last_o) |=> (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));

  p_bl4_bit2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !len8) |-> (col_o[2] == slow[2]));

  p_last_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (last_o == (cnt == (len8 ? 3'd7 : 3'd3))));

  p_last_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && last_o) |=> !valid_o);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(col_o) && $stable(last_o)));

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !last_o && start_i) |=> valid_o);
endmodule

bind burst_col_seq bsq_checker #(.COL_W(COL_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .bl8_i       (bl8_i),
  .intlv_i     (intlv_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .ready_i     (ready_i),
  .last_o      (last_o)
);

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic             bl8_i = 1'b0;
  logic             intlv_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             ready_i = 1'b0;
  logic             last_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int cyc = 0;

  always #4 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .bl8_i(bl8_i), .intlv_i(intlv_i), .col_o(col_o), .valid_o(valid_o),
    .ready_i(ready_i), .last_o(last_o)
  );

  function automatic logic [COL_W-1:0] ref_col(logic [COL_W-1:0] s, bit b8, bit il, int i);
    logic [COL_W-1:0] r;
    logic [2:0] k;
    k = 3'(i);
    r = s;
    if (il) begin
      if (b8) r[2:0] = s[2:0] ^ k;
      else    r[1:0] = s[1:0] ^ k[1:0];
    end else begin
      r[1:0] = 2'((int'(s[1:0]) + i) % 4);
      if (b8 && i >= 4) r[2] = ~s[2];
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(bit b8, bit il);
    if (!b8 && !il) return "R3";
    if (!b8 &&  il) return "R4";
    if ( b8 && !il) return "R5";
    return "R6";
  endfunction

  task automatic run_burst(logic [COL_W-1:0] s, bit b8, bit il, int bp_pct, bit inject);
    int len;
    int idx;
    bit hs;
    logic [COL_W-1:0] e;
    logic [COL_W-1:0] up_mask;
    len = b8 ? 8 : 4;
    up_mask = b8 ? ~COL_W'(7) : ~COL_W'(3);
    @(negedge clk);
    start_i = 1'b1; start_col_i = s; bl8_i = b8; intlv_i = il; ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk(valid_o === 1'b1 && col_o === s, "R2", {valid_o, col_o}, {1'b1, s});
    idx = 0;
    while (idx < len) begin
      e = ref_col(s, b8, il, idx);
      chk(valid_o === 1'b1 && col_o === e, tag_of(b8, il), col_o, e);
      chk((col_o & up_mask) === (s & up_mask), "R7", col_o & up_mask, s & up_mask);
      chk(last_o === (idx == len - 1), "R8", last_o, idx == len - 1);
      hs = (($urandom % 100) >= bp_pct);
      ready_i = hs;
      // R9: a stalled cycle must show the same beat again at the next sample
      // R10: random start pulses with foreign parameters during the burst
      start_i = inject && (($urandom % 3) == 0);
      start_col_i = COL_W'($urandom);
      bl8_i = ~b8; intlv_i = ~il;
      @(negedge clk);
      if (hs) idx++;
      else begin
        chk(col_o === e && valid_o === 1'b1, "R9", col_o, e);
      end
    end
    ready_i = 1'b0; start_i = 1'b0;
    chk(valid_o === 1'b0, "R8", valid_o, 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: idle after reset, a start while reset is held is not taken
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(valid_o === 1'b0, "R1", valid_o, 0);
    chk(last_o === 1'b0, "R1", last_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(valid_o === 1'b0 && last_o === 1'b0, "R1", {valid_o, last_o}, 0);

    // directed corners
    run_burst(COL_W'(1), 1'b1, 1'b0, 0, 1'b0);      // 1,2,3,0,5,6,7,4 (R5)
    run_burst(COL_W'(6), 1'b1, 1'b0, 0, 1'b0);      // R5 upper nibble start
    run_burst(COL_W'(2), 1'b0, 1'b0, 0, 1'b0);      // R3
    run_burst(COL_W'(3), 1'b0, 1'b1, 0, 1'b0);      // R4
    run_burst(COL_W'(5), 1'b1, 1'b1, 0, 1'b0);      // R6
    run_burst('1, 1'b1, 1'b1, 50, 1'b1);            // R7 top group, R9, R10
    run_burst('1, 1'b0, 1'b0, 50, 1'b1);            // R7 four-beat wrap
    run_burst(COL_W'(8'hF8), 1'b1, 1'b0, 70, 1'b1); // R9 heavy stall

    // random mix
    for (int t = 0; t < 300; t++) begin
      run_burst(COL_W'($urandom), 1'($urandom), 1'($urandom),
                int'($urandom % 60), 1'($urandom));
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule